// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block pulls outgoing frames from memory by walking a ring of two-word descriptors. Each descriptor has a buffer address word and a control word. Software prepares a descriptor, clears its ownership flag so the block may use it, and pulses start. The block then reads the buffer one 32-bit word at a time and delivers it as a byte stream with backpressure. When it has finished with a buffer, it writes the control word back with the ownership flag set, so software knows it may reuse the buffer.

The ring pointer moves eight bytes per descriptor and returns to the programmed ring base after any descriptor that carries the wrap flag. Processing stops cleanly at the first descriptor the block does not own. A frame may span several buffers and ends at the buffer whose end-of-frame flag is set.

Errors are reported in the same control word that hands ownership back: a starved byte consumer (underrun) and a frame whose next buffer is not available (exhaustion). A halt request lets the current frame finish before the block stops. Dropping the enable stops the block at once and points it back at the ring base.

Top module: `txd_ring_reader`

## Requirements
- R1: After reset, busy and tx_valid are low and no memory read or write is issued.
- R2: With tx_en high, a start pulse makes the block read the control word at pointer+4. If bit 31 of that word is clear, it reads the buffer address at the pointer and streams the number of bytes given in bits 10:0. Within each 32-bit word, bits 7:0 are sent first.
- R3: While tx_valid is high, tx_nocrc equals bit 16 of the control word of the buffer being streamed.
- R4: After a buffer has been streamed, its control word is written back unchanged except that bit 31 (used) is set.
- R5: After a descriptor with bit 30 set, the next descriptor is read at the ring base. After any other descriptor, the next one is at pointer+8.
- R6: A descriptor with bit 31 set, found at the start of a frame, stops the block: busy goes low, no byte is sent, and that descriptor is not written.
- R7: A descriptor with bit 31 set, found after a buffer whose bit 15 was clear, gets its control word written back with bit 27 (exhausted) set, and the block stops.
- R8: tx_underrun asserted while a buffer is being read or streamed aborts the buffer. The byte offered in that cycle is not consumed. The control word is written back with bits 31 and 28 set, and the block stops.
- R9: A tx_halt pulse during a frame lets that frame complete, then busy goes low. The next start resumes at the following descriptor.
- R10: tx_en low drops busy and tx_valid in the next cycle and returns the descriptor pointer to the ring base.
- R11: While tx_valid is high and tx_ready is low, tx_data, tx_last and tx_nocrc hold their values.
- R12: A frame's buffers are streamed back to back. tx_last is high only on the final byte of the buffer whose control bit 15 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit enable; low resets the pointer to the ring base |
| tx_start | input | 1 | Start pulse, taken when idle |
| tx_halt | input | 1 | Halt request, acted on at the end of the frame |
| ring_base | input | AW | Byte address of the first descriptor |
| busy | output | 1 | High while descriptors are being processed |
| mem_rd | output | 1 | Memory read request; data returns one cycle later |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | AW | Byte address of the word being accessed |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data for the request of the previous cycle |
| tx_valid | output | 1 | A byte is offered |
| tx_ready | input | 1 | The consumer takes the offered byte |
| tx_data | output | 8 | Byte being offered |
| tx_last | output | 1 | The offered byte ends the frame |
| tx_nocrc | output | 1 | The frame must go out without a CRC |
| tx_underrun | input | 1 | The consumer ran dry; aborts the current buffer |

## Verification
The bench tries single-buffer frames with lengths of one byte, one exact word, a partial second word and four full words. These separate a wrong byte order, an off-by-one in the remaining count and a word-boundary fetch bug. Some of these frames run under a toggling tx_ready, so backpressure is exercised. A two-buffer frame ending on a wrap descriptor shows concatenation and the return to the ring base. Unowned descriptors placed at a frame start and in mid-frame tell the clean stop apart from the exhaustion error. Underrun, halt and enable-drop sequences then show the write-back contents and the restart point that each exit leaves behind.

// File: rtl/txd_pkg.sv
// Shared constants and types for the transmit descriptor ring reader.
// Assumes 32-bit memory words and descriptors of two words (8 bytes).
package txd_pkg;
    localparam int WORD_W    = 32;
    localparam int LEN_W     = 11;
    localparam int DESC_B    = 8;
    localparam int BIT_LAST  = 15;
    localparam int BIT_NOCRC = 16;
    localparam int BIT_EXH   = 27;
    localparam int BIT_UNR   = 28;
    localparam int BIT_WRAP  = 30;
    localparam int BIT_USED  = 31;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CTRL_RQ,
        S_CTRL_CP,
        S_ADDR_RQ,
        S_ADDR_CP,
        S_DATA_RQ,
        S_DATA_CP,
        S_STREAM,
        S_WB,
        S_EXH_WB
    } seq_state_t;
endpackage

// File: rtl/txd_ring_ptr.sv
// Descriptor pointer of the ring.
// Loads the ring base while load_base is high. On advance it steps one
// descriptor, or returns to the base when the finished descriptor wraps.
// Assumes the base is aligned to a descriptor.
module txd_ring_ptr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base,
    input  logic          load_base,
    input  logic          advance,
    input  logic          wrap,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] STEP = AW'(txd_pkg::DESC_B);

    // Pointer register: base load has priority over advance.
    always_ff @(posedge clk) begin
        if (!rst_n)         ptr <= '0;
        else if (load_base) ptr <= base;
        else if (advance)   ptr <= wrap ? base : ptr + STEP;
    end

    p_wrap_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
        advance && wrap && !load_base |=> ptr == $past(base))
        else $error("wrap did not return to base");

    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !wrap && !load_base |=> ptr == $past(ptr) + STEP)
        else $error("pointer step wrong");

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !advance && !load_base |=> $stable(ptr))
        else $error("pointer moved without advance");
endmodule

// File: rtl/txd_byte_pack.sv
// Word-to-byte serializer for one buffer.
// Holds the current data word and the number of bytes left in the buffer,
// and offers the byte lanes in ascending order. Assumes buffers start on a
// word boundary.
module txd_byte_pack #(
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_len,
    input  logic [LW-1:0] len,
    input  logic          load_word,
    input  logic [31:0]   word,
    input  logic          take,
    output logic [7:0]    byte_o,
    output logic          last_of_word,
    output logic          last_of_buf
);
    localparam int LANES = 4;

    logic [31:0]   word_q;
    logic [1:0]    idx;
    logic [LW-1:0] rem;
    logic [7:0]    lane [LANES];

    // Split the held word into byte lanes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word_q[8*g +: 8];
    end

    // Remaining count, lane index and data word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            idx    <= '0;
            rem    <= '0;
        end else begin
            if (load_len) begin
                rem <= len;
                idx <= '0;
            end else if (take) begin
                rem <= rem - LW'(1);
                idx <= idx + 2'd1;
            end
            if (load_word) word_q <= word;
        end
    end

    // Byte select and end flags.
    always_comb begin
        byte_o       = lane[idx];
        last_of_word = (idx == 2'd3);
        last_of_buf  = (rem == LW'(1));
    end

    p_take_count_r12: assert property (@(posedge clk) disable iff (!rst_n)
        take && !load_len |=> rem == $past(rem) - LW'(1))
        else $error("remaining count not decremented");

    p_no_take_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> rem != '0)
        else $error("byte taken past end of buffer");
endmodule

// File: rtl/txd_seq.sv
// Sequencer of the transmit descriptor ring reader.
// Fetches the control and address words, requests data words, drives the
// byte stream handshake and writes status back. Memory reads return one
// cycle after the request. Halt is honoured only at frame end.
module txd_seq #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic          tx_start,
    input  logic          tx_halt,
    input  logic          tx_underrun,
    output logic          busy,
    input  logic [AW-1:0] ptr,
    output logic          ptr_load_base,
    output logic          ptr_advance,
    output logic          ptr_wrap,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          pk_load_len,
    output logic [txd_pkg::LEN_W-1:0] pk_len,
    output logic          pk_load_word,
    output logic [31:0]   pk_word,
    output logic          pk_take,
    input  logic          pk_last_of_word,
    input  logic          pk_last_of_buf,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic          tx_last,
    output logic          tx_nocrc
);
    import txd_pkg::*;

    localparam logic [AW-1:0] CTRL_OFS = AW'(4);
    localparam logic [AW-1:0] WORD_B   = AW'(4);

    seq_state_t    state, nxt;
    logic [31:0]   ctrl_q;
    logic [AW-1:0] buf_addr;
    logic          in_frame;
    logic          halt_pend;
    logic          unr_flag;
    logic          abort;

    // Handshake, memory request and status outputs decoded from the state.
    always_comb begin
        busy          = (state != S_IDLE);
        abort         = tx_underrun && (state inside {S_DATA_RQ, S_DATA_CP, S_STREAM});
        tx_valid      = (state == S_STREAM);
        pk_take       = tx_valid && tx_ready && !tx_underrun;
        tx_last       = tx_valid && pk_last_of_buf && ctrl_q[BIT_LAST];
        tx_nocrc      = tx_valid && ctrl_q[BIT_NOCRC];
        pk_load_len   = (state == S_ADDR_CP);
        pk_len        = ctrl_q[LEN_W-1:0];
        pk_load_word  = (state == S_DATA_CP);
        pk_word       = mem_rdata;
        ptr_load_base = !tx_en;
        ptr_advance   = (state == S_WB) && tx_en;
        ptr_wrap      = ctrl_q[BIT_WRAP];
        mem_rd        = state inside {S_CTRL_RQ, S_ADDR_RQ, S_DATA_RQ};
        mem_wr        = state inside {S_WB, S_EXH_WB};
        mem_wdata     = ctrl_q;
        mem_addr      = ptr + CTRL_OFS;
        case (state)
            S_ADDR_RQ: mem_addr = ptr;
            S_DATA_RQ: mem_addr = buf_addr;
            default:   mem_addr = ptr + CTRL_OFS;
        endcase
        if (state == S_WB) begin
            mem_wdata[BIT_USED] = 1'b1;
            if (unr_flag) mem_wdata[BIT_UNR] = 1'b1;
        end
        if (state == S_EXH_WB) mem_wdata[BIT_EXH] = 1'b1;
    end

    // Next-state selection; enable drop and underrun override.
    always_comb begin
        nxt = state;
        case (state)
            S_IDLE:    if (tx_start) nxt = S_CTRL_RQ;
            S_CTRL_RQ: nxt = S_CTRL_CP;
            S_CTRL_CP: begin
                if (mem_rdata[BIT_USED]) nxt = in_frame ? S_EXH_WB : S_IDLE;
                else                     nxt = S_ADDR_RQ;
            end
            S_ADDR_RQ: nxt = S_ADDR_CP;
            S_ADDR_CP: nxt = (ctrl_q[LEN_W-1:0] == '0) ? S_WB : S_DATA_RQ;
            S_DATA_RQ: nxt = S_DATA_CP;
            S_DATA_CP: nxt = S_STREAM;
            S_STREAM: begin
                if (pk_take) begin
                    if (pk_last_of_buf)       nxt = S_WB;
                    else if (pk_last_of_word) nxt = S_DATA_RQ;
                end
            end
            S_WB: begin
                if (unr_flag)                                    nxt = S_IDLE;
                else if (ctrl_q[BIT_LAST] && (halt_pend || tx_halt)) nxt = S_IDLE;
                else                                             nxt = S_CTRL_RQ;
            end
            S_EXH_WB:  nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
        if (abort)  nxt = S_WB;
        if (!tx_en) nxt = S_IDLE;
    end

    // State, captured descriptor words and frame flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            ctrl_q    <= '0;
            buf_addr  <= '0;
            in_frame  <= 1'b0;
            halt_pend <= 1'b0;
            unr_flag  <= 1'b0;
        end else begin
            state <= nxt;
            if (state == S_CTRL_CP) ctrl_q <= mem_rdata;
            if (state == S_ADDR_CP) buf_addr <= AW'(mem_rdata) & ~AW'(3);
            else if (state == S_DATA_RQ) buf_addr <= buf_addr + WORD_B;
            if (nxt == S_IDLE) begin
                in_frame  <= 1'b0;
                halt_pend <= 1'b0;
                unr_flag  <= 1'b0;
            end else begin
                if (state == S_WB) in_frame <= !ctrl_q[BIT_LAST];
                if (tx_halt && state != S_IDLE) halt_pend <= 1'b1;
                if (abort) unr_flag <= 1'b1;
            end
        end
    end

    p_start_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_IDLE && tx_en && tx_start |=>
            (!tx_en || (mem_rd && mem_addr == $past(ptr) + CTRL_OFS)))
        else $error("start did not fetch control word");

    p_exh_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_EXH_WB |=> !busy)
        else $error("block kept running after exhaustion");

    p_end_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last && pk_take |=> !tx_valid)
        else $error("byte offered right after frame end");

    p_en_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !busy && !tx_valid)
        else $error("busy after enable dropped");

    p_unr_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort && tx_en |=> mem_wr && mem_wdata[BIT_UNR] && mem_wdata[BIT_USED])
        else $error("underrun not written back");
endmodule

// File: rtl/txd_ring_reader.sv
// Top of the transmit descriptor ring reader.
// Connects the ring pointer, the sequencer and the byte serializer.
// Memory reads have a fixed latency of one cycle, and writes complete in
// the cycle they are issued.
module txd_ring_reader #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic          tx_start,
    input  logic          tx_halt,
    input  logic [AW-1:0] ring_base,
    output logic          busy,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    output logic          tx_nocrc,
    input  logic          tx_underrun
);
    logic [AW-1:0]             ptr;
    logic                      ptr_load_base, ptr_advance, ptr_wrap;
    logic                      pk_load_len, pk_load_word, pk_take;
    logic [txd_pkg::LEN_W-1:0] pk_len;
    logic [31:0]               pk_word;
    logic                      pk_last_of_word, pk_last_of_buf;

    txd_ring_ptr #(.AW(AW)) ptr_i (
        .clk(clk), .rst_n(rst_n), .base(ring_base), .load_base(ptr_load_base),
        .advance(ptr_advance), .wrap(ptr_wrap), .ptr(ptr)
    );

    txd_seq #(.AW(AW)) seq_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_start(tx_start),
        .tx_halt(tx_halt), .tx_underrun(tx_underrun), .busy(busy), .ptr(ptr),
        .ptr_load_base(ptr_load_base), .ptr_advance(ptr_advance), .ptr_wrap(ptr_wrap),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pk_load_len(pk_load_len), .pk_len(pk_len), .pk_load_word(pk_load_word),
        .pk_word(pk_word), .pk_take(pk_take), .pk_last_of_word(pk_last_of_word),
        .pk_last_of_buf(pk_last_of_buf), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_last(tx_last), .tx_nocrc(tx_nocrc)
    );

    txd_byte_pack #(.LW(txd_pkg::LEN_W)) pack_i (
        .clk(clk), .rst_n(rst_n), .load_len(pk_load_len), .len(pk_len),
        .load_word(pk_load_word), .word(pk_word), .take(pk_take),
        .byte_o(tx_data), .last_of_word(pk_last_of_word), .last_of_buf(pk_last_of_buf)
    );

    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready && !tx_underrun && tx_en |=>
            tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_nocrc))
        else $error("stream changed while stalled");
endmodule

// File: tb/txd_ring_reader_tb_top.sv
// Bench for txd_ring_reader: a table of single-buffer frames followed by
// directed tests for ring wrap, stop conditions, errors, halt and enable.
module txd_ring_reader_tb_top;
    localparam int AW = 32;
    localparam logic [31:0] USED = 32'h8000_0000;

    typedef struct packed {
        logic [10:0] len;
        logic        nocrc;
        logic        stall;
        logic [7:0]  seed;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{len: 11'd1,  nocrc: 1'b0, stall: 1'b0, seed: 8'h10},
        '{len: 11'd4,  nocrc: 1'b1, stall: 1'b0, seed: 8'h20},
        '{len: 11'd7,  nocrc: 1'b0, stall: 1'b1, seed: 8'h30},
        '{len: 11'd16, nocrc: 1'b1, stall: 1'b1, seed: 8'hF8}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_en = 1'b0, tx_start = 1'b0, tx_halt = 1'b0;
    logic [AW-1:0] ring_base = '0;
    logic          busy, mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          tx_valid, tx_last, tx_nocrc;
    logic          tx_ready = 1'b1, tx_underrun = 1'b0;
    logic [7:0]    tx_data;

    logic [31:0] mem [64];
    logic [7:0]  cap_d [64];
    logic        cap_l [64];
    logic        cap_n [64];
    int          cap_cnt = 0;
    int          tests = 0;
    int          fails = 0;

    always #5 clk = ~clk;

    txd_ring_reader #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_start(tx_start),
        .tx_halt(tx_halt), .ring_base(ring_base), .busy(busy),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last), .tx_nocrc(tx_nocrc), .tx_underrun(tx_underrun)
    );

    // Memory model with one cycle of read latency.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:2]];
        if (mem_wr) mem[mem_addr[7:2]] <= mem_wdata;
    end

    // Byte consumer: records every accepted byte.
    always @(posedge clk) begin
        if (rst_n && tx_valid && tx_ready && !tx_underrun) begin
            if (cap_cnt < 64) begin
                cap_d[cap_cnt] = tx_data;
                cap_l[cap_cnt] = tx_last;
                cap_n[cap_cnt] = tx_nocrc;
            end
            cap_cnt = cap_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mkctrl(input int len, input bit last, input bit nocrc,
                                           input bit wrap, input bit used);
        logic [31:0] c;
        c = 32'(len) & 32'h7FF;
        c[15] = last;
        c[16] = nocrc;
        c[30] = wrap;
        c[31] = used;
        return c;
    endfunction

    task automatic set_desc(input int idx, input logic [31:0] baddr, input logic [31:0] ctrl);
        mem[idx*2]   = baddr;
        mem[idx*2+1] = ctrl;
    endtask

    task automatic fill_buf(input int addr, input int len, input logic [7:0] seed);
        for (int k = 0; k < len; k++)
            mem[(addr + k) / 4][8*((addr + k) % 4) +: 8] = seed + 8'(k);
    endtask

    task automatic pulse_start();
        @(negedge clk) tx_start = 1'b1;
        @(negedge clk) tx_start = 1'b0;
    endtask

    task automatic en_cycle();
        @(negedge clk) tx_en = 1'b0;
        @(negedge clk) tx_en = 1'b1;
    endtask

    // Wait for busy to drop; optionally toggle ready and track stall holds.
    task automatic wait_idle(input bit stall, output int hold_bad);
        logic [7:0] pd;
        bit ps;
        hold_bad = 0;
        ps = 1'b0;
        pd = '0;
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            if (ps && tx_valid && tx_data != pd) hold_bad++;
            if (!busy) break;
            if (stall) tx_ready = ~tx_ready;
            ps = tx_valid && !tx_ready;
            pd = tx_data;
        end
        tx_ready = 1'b1;
    endtask

    function automatic int bytes_bad(input int off, input int n, input logic [7:0] seed);
        int b = 0;
        for (int k = 0; k < n; k++)
            if (cap_d[off + k] != seed + 8'(k)) b++;
        return b;
    endfunction

    function automatic int last_bad(input int n);
        int b = 0;
        for (int k = 0; k < n; k++)
            if (cap_l[k] != (k == n - 1)) b++;
        return b;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog ALL actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int hb, nb;
        logic [31:0] c0, c1;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        chk(!busy && !tx_valid, "R1 busy/valid after reset", {busy, tx_valid}, 0);
        chk(!mem_rd && !mem_wr, "R1 memory idle after reset", {mem_rd, mem_wr}, 0);
        tx_en = 1'b1;

        // Table of single-buffer frames (R2, R3, R4, R6, R11, R12)
        foreach (VEC[i]) begin
            en_cycle();
            cap_cnt = 0;
            c0 = mkctrl(int'(VEC[i].len), 1'b1, VEC[i].nocrc, 1'b0, 1'b0);
            c1 = mkctrl(4, 1'b1, 1'b0, 1'b0, 1'b1);
            set_desc(0, 32'h40, c0);
            set_desc(1, 32'h80, c1);
            fill_buf(32'h40, int'(VEC[i].len), VEC[i].seed);
            tx_ready = !VEC[i].stall;
            pulse_start();
            wait_idle(VEC[i].stall, hb);
            chk(cap_cnt == int'(VEC[i].len), "R2 byte count", cap_cnt, VEC[i].len);
            nb = bytes_bad(0, int'(VEC[i].len), VEC[i].seed);
            chk(nb == 0, "R2 byte values", nb, 0);
            nb = last_bad(int'(VEC[i].len));
            chk(nb == 0, "R12 end marker position", nb, 0);
            nb = 0;
            for (int k = 0; k < int'(VEC[i].len); k++) if (cap_n[k] != VEC[i].nocrc) nb++;
            chk(nb == 0, "R3 no-CRC sideband", nb, 0);
            chk(mem[1] == (c0 | USED), "R4 write-back", mem[1], c0 | USED);
            chk(mem[3] == c1, "R6 owned-by-software stop", mem[3], c1);
            if (VEC[i].stall) chk(hb == 0, "R11 stall hold", hb, 0);
        end

        // R12/R5: two-buffer frame ending on a wrap descriptor
        en_cycle();
        cap_cnt = 0;
        c0 = mkctrl(6, 1'b0, 1'b0, 1'b0, 1'b0);
        c1 = mkctrl(5, 1'b1, 1'b0, 1'b1, 1'b0);
        set_desc(0, 32'h40, c0);
        set_desc(1, 32'h80, c1);
        set_desc(2, 32'hC0, mkctrl(4, 1'b1, 1'b0, 1'b0, 1'b1));
        fill_buf(32'h40, 6, 8'h50);
        fill_buf(32'h80, 5, 8'h60);
        pulse_start();
        wait_idle(1'b0, hb);
        chk(cap_cnt == 11, "R12 multi-buffer count", cap_cnt, 11);
        nb = bytes_bad(0, 6, 8'h50) + bytes_bad(6, 5, 8'h60);
        chk(nb == 0, "R12 multi-buffer bytes", nb, 0);
        nb = last_bad(11);
        chk(nb == 0, "R12 end marker only at frame end", nb, 0);
        chk(mem[1] == (c0 | USED), "R4 first buffer write-back", mem[1], c0 | USED);
        chk(mem[3] == (c1 | USED), "R4 second buffer write-back", mem[3], c1 | USED);
        cap_cnt = 0;
        c0 = mkctrl(3, 1'b1, 1'b0, 1'b0, 1'b0);
        set_desc(0, 32'h40, c0);
        fill_buf(32'h40, 3, 8'h70);
        pulse_start();
        wait_idle(1'b0, hb);
        nb = bytes_bad(0, 3, 8'h70);
        chk(cap_cnt == 3 && nb == 0, "R5 restart at base after wrap", cap_cnt, 3);

        // R7: unowned descriptor in the middle of a frame
        en_cycle();
        cap_cnt = 0;
        c0 = mkctrl(4, 1'b0, 1'b0, 1'b0, 1'b0);
        set_desc(0, 32'h40, c0);
        set_desc(1, 32'h80, USED);
        fill_buf(32'h40, 4, 8'h11);
        pulse_start();
        wait_idle(1'b0, hb);
        chk(mem[3] == 32'h8800_0000, "R7 exhausted flag", mem[3], 32'h8800_0000);
        chk(mem[1] == (c0 | USED) && cap_cnt == 4, "R7 first buffer done", mem[1], c0 | USED);

        // R6: unowned descriptor at frame start
        en_cycle();
        cap_cnt = 0;
        c0 = mkctrl(4, 1'b1, 1'b0, 1'b0, 1'b1);
        set_desc(0, 32'h40, c0);
        pulse_start();
        wait_idle(1'b0, hb);
        chk(cap_cnt == 0, "R6 no bytes sent", cap_cnt, 0);
        chk(mem[1] == c0, "R6 descriptor untouched", mem[1], c0);

        // R8: underrun after two bytes
        en_cycle();
        cap_cnt = 0;
        c0 = mkctrl(12, 1'b1, 1'b0, 1'b0, 1'b0);
        set_desc(0, 32'h40, c0);
        set_desc(1, 32'h80, USED);
        fill_buf(32'h40, 12, 8'h22);
        pulse_start();
        for (int n = 0; n < 200 && cap_cnt < 2; n++) @(negedge clk);
        tx_underrun = 1'b1;
        @(negedge clk) tx_underrun = 1'b0;
        wait_idle(1'b0, hb);
        chk(cap_cnt == 2, "R8 bytes before abort", cap_cnt, 2);
        chk(mem[1] == (c0 | 32'h9000_0000), "R8 underrun write-back", mem[1], c0 | 32'h9000_0000);
        chk(mem[3] == USED, "R8 next descriptor untouched", mem[3], USED);

        // R9: halt completes the frame, then start resumes
        en_cycle();
        cap_cnt = 0;
        c1 = mkctrl(4, 1'b1, 1'b0, 1'b0, 1'b0);
        set_desc(0, 32'h40, mkctrl(4, 1'b1, 1'b0, 1'b0, 1'b0));
        set_desc(1, 32'h80, c1);
        set_desc(2, 32'hC0, USED);
        fill_buf(32'h40, 4, 8'h33);
        fill_buf(32'h80, 4, 8'h44);
        pulse_start();
        @(negedge clk) tx_halt = 1'b1;
        @(negedge clk) tx_halt = 1'b0;
        wait_idle(1'b0, hb);
        chk(cap_cnt == 4 && bytes_bad(0, 4, 8'h33) == 0, "R9 frame completes", cap_cnt, 4);
        chk(mem[3] == c1, "R9 next frame held", mem[3], c1);
        cap_cnt = 0;
        pulse_start();
        wait_idle(1'b0, hb);
        nb = bytes_bad(0, 4, 8'h44);
        chk(cap_cnt == 4 && nb == 0, "R9 resume at next descriptor", cap_cnt, 4);

        // R10: enable drop mid-frame, pointer back to base
        set_desc(2, 32'hC0, mkctrl(8, 1'b1, 1'b0, 1'b0, 1'b0));
        fill_buf(32'hC0, 8, 8'h55);
        tx_ready = 1'b0;
        pulse_start();
        for (int n = 0; n < 50 && !tx_valid; n++) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk(!tx_valid && !busy, "R10 stop on enable drop", {tx_valid, busy}, 0);
        set_desc(0, 32'h40, mkctrl(4, 1'b1, 1'b0, 1'b0, 1'b0));
        set_desc(1, 32'h80, USED);
        fill_buf(32'h40, 4, 8'h66);
        tx_ready = 1'b1;
        cap_cnt = 0;
        @(negedge clk) tx_en = 1'b1;
        pulse_start();
        wait_idle(1'b0, hb);
        nb = bytes_bad(0, 4, 8'h66);
        chk(cap_cnt == 4 && nb == 0, "R10 restart at ring base", cap_cnt, 4);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule